// File: doc/BRIEF.md
# Open-Drain Capable GPIO Port

This block controls a sixteen-line general-purpose I/O port. Software reaches it over a small register bus with a combinational read path. One register holds the value each line drives. The other register selects, for each line, whether the line is an input or an output. Two lines, 8 and 10, can also switch to open-drain signalling. In that mode the line pulls low when its data bit is 0 and releases the pad (output enable off) when its data bit is 1.

The block drives a per-line output enable and output value toward the pad drivers. It samples the pad inputs through a synchronizer, so the data address reads back the driven value on output lines and the pad level on input lines. Two resets exist. Hard reset clears the direction bits of lines 6 to 15 and empties the data register. Soft reset clears only the data register and leaves the configuration register unchanged.

Bit layout of the configuration word (bit 0 = LSB): bit 0 enables open-drain on line 8, bit 1 enables open-drain on line 10, bit 2 is reserved, and bit k (k = 3..15) is the direction of line k (1 = output). Lines 0 to 2 have no direction bit.

Top module: `gpio_od_port`

## Requirements
- R1: A hard reset sets configuration bits 6 to 15 to 0, so lines 6 to 15 become inputs with pad_oe low. It also clears the data register. Configuration bits 0, 1, 3, 4 and 5 keep whatever value they held.
- R2: Soft reset leaves every configuration bit unchanged. The configuration word reads back the same value afterwards.
- R3: Configuration bit 2 always reads 0. Writing 1 to it changes nothing.
- R4: A line k ≥ 3 whose direction bit is 1 and which has no open-drain enabled has pad_oe[k]=1 and pad_out[k] equal to data bit k.
- R5: A line whose direction bit is 0 has pad_oe low, whatever its data bit.
- R6: Line 8 or 10 with its open-drain bit set and its direction bit 1 has pad_out low. pad_oe is 1 when the data bit is 0 and 0 when the data bit is 1.
- R7: An open-drain enable on a line whose direction bit is 0 never turns pad_oe on. On such a line pad_out still reads 0.
- R8: Lines 0, 1 and 2 have pad_oe permanently 0. Their pad_out follows their data bits.
- R9: A read at address 0 returns, per line, the data bit for output lines and the synchronized pad level for input lines. A pad change becomes visible two clock edges after it is applied.
- R10: Soft reset clears the data register to 0 on the next edge.
- R11: Address 0 is the data register and address 1 is the configuration register. A write takes effect at the next edge. Addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard | input | 1 | Synchronous active-high hard reset |
| rst_soft | input | 1 | Synchronous active-high soft reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Per-line output enable to the pad |
| pad_out | output | 16 | Per-line driven value |

## Verification
The bench sets both open-drain bits with data 1 and with data 0. A design that drove the high level actively would show pad_oe set where it must be off. It checks that the open-drain bits are harmless on input lines and that bit 2 stays at zero after a write of all ones. A design that stored the reserved bit, or let an open-drain bit force an enable, would read back a wrong word.

A soft reset between configuration and readback exposes a design that wipes the configuration register. A hard reset after writing all ones exposes one that misses bits 6 to 15. A pad edge sampled in two consecutive cycles separates a correct two-stage synchronizer from one that is too short or too long.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

    localparam int PORT_W      = 16;
    localparam int ADDR_W      = 2;
    localparam int DIR_LO      = 3;
    localparam int HARD_CLR_LO = 6;
    localparam int OD_LINE_A   = 8;
    localparam int OD_LINE_B   = 10;
    localparam int OD_BIT_A    = 0;
    localparam int OD_BIT_B    = 1;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CFG  = 2'd1
    } addr_e;

    typedef struct packed {
        logic [PORT_W-1:DIR_LO] dir;
        logic                   od_b;
        logic                   od_a;
    } cfg_t;

    function automatic logic [PORT_W-1:0] cfg_pack(input cfg_t c);
        logic [PORT_W-1:0] w;
        w                   = '0;
        w[PORT_W-1:DIR_LO]  = c.dir;
        w[OD_BIT_A]         = c.od_a;
        w[OD_BIT_B]         = c.od_b;
        return w;
    endfunction

    function automatic cfg_t cfg_unpack(input logic [PORT_W-1:0] w);
        cfg_t c;
        c.dir  = w[PORT_W-1:DIR_LO];
        c.od_a = w[OD_BIT_A];
        c.od_b = w[OD_BIT_B];
        return c;
    endfunction

    function automatic logic [PORT_W-1:0] out_lines(input cfg_t c);
        logic [PORT_W-1:0] m;
        m                  = '0;
        m[PORT_W-1:DIR_LO] = c.dir;
        return m;
    endfunction

endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_od_pkg::*;
(
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_soft,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_word,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst_hard) begin
            cfg.dir[PORT_W-1:HARD_CLR_LO] <= '0;
        end else if (wr_en) begin
            cfg <= cfg_unpack(wr_word);
        end
    end

    assert_hard_clear_R1: assert property (@(posedge clk)
        rst_hard |=> (cfg.dir[PORT_W-1:HARD_CLR_LO] == '0));

    assert_soft_keep_R2: assert property (@(posedge clk) disable iff (rst_hard)
        (rst_soft && !wr_en) |=> (cfg == $past(cfg)));

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg
    import gpio_od_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_soft,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_word,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] pad_sync
);

    logic [PORT_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst_hard || rst_soft) begin
            data_q <= '0;
        end else if (wr_en) begin
            data_q <= wr_word;
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst_hard) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? pad_in : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign pad_sync = stage_q[STAGES-1];

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst_hard)
        rst_soft |=> (data_q == '0));

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (rst_hard)
        (wr_en && !rst_soft) |=> (data_q == $past(wr_word)));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_od_pkg::*;
(
    input  logic              clk,
    input  logic              rst_hard,
    input  cfg_t              cfg,
    input  logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_line
        if (i < DIR_LO) begin : g_fixed_in
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = data_q[i];
        end else if (i == OD_LINE_A || i == OD_LINE_B) begin : g_od
            logic od_en;
            assign od_en      = (i == OD_LINE_A) ? cfg.od_a : cfg.od_b;
            assign pad_oe[i]  = cfg.dir[i] & (od_en ? ~data_q[i] : 1'b1);
            assign pad_out[i] = od_en ? 1'b0 : data_q[i];

            assert_od_no_high_R6: assert property (@(posedge clk) disable iff (rst_hard)
                (od_en && pad_oe[i]) |-> (pad_out[i] == 1'b0 && data_q[i] == 1'b0));
        end else begin : g_push_pull
            assign pad_oe[i]  = cfg.dir[i];
            assign pad_out[i] = data_q[i];
        end
    end

    for (genvar k = DIR_LO; k < PORT_W; k++) begin : g_chk
        assert_input_quiet_R5: assert property (@(posedge clk) disable iff (rst_hard)
            !cfg.dir[k] |-> !pad_oe[k]);
    end

endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
    import gpio_od_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_soft,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);

    cfg_t              cfg;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] pad_sync;
    logic [PORT_W-1:0] drive_mask;
    logic              we_data;
    logic              we_cfg;

    assign we_data = bus_we && (addr_e'(bus_addr) == ADDR_DATA);
    assign we_cfg  = bus_we && (addr_e'(bus_addr) == ADDR_CFG);

    gpio_cfg_reg u_cfg (
        .clk      (clk),
        .rst_hard (rst_hard),
        .rst_soft (rst_soft),
        .wr_en    (we_cfg),
        .wr_word  (bus_wdata),
        .cfg      (cfg)
    );

    gpio_data_reg #(.STAGES(SYNC_STAGES)) u_data (
        .clk      (clk),
        .rst_hard (rst_hard),
        .rst_soft (rst_soft),
        .wr_en    (we_data),
        .wr_word  (bus_wdata),
        .pad_in   (pad_in),
        .data_q   (data_q),
        .pad_sync (pad_sync)
    );

    gpio_pad_drive u_drive (
        .clk      (clk),
        .rst_hard (rst_hard),
        .cfg      (cfg),
        .data_q   (data_q),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    assign drive_mask = out_lines(cfg);

    always_comb begin
        case (addr_e'(bus_addr))
            ADDR_DATA: bus_rdata = (data_q & drive_mask) | (pad_sync & ~drive_mask);
            ADDR_CFG:  bus_rdata = cfg_pack(cfg);
            default:   bus_rdata = '0;
        endcase
    end

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst_hard)
        (addr_e'(bus_addr) == ADDR_CFG) |-> (bus_rdata[DIR_LO-1] == 1'b0));

    assert_low_lines_in_R8: assert property (@(posedge clk) disable iff (rst_hard)
        pad_oe[DIR_LO-1:0] == '0);

endmodule

// File: tb/gpio_od_port_bench.sv
module gpio_od_port_bench;

    typedef struct {
        string       req;
        bit          is_pad;
        logic [31:0] exp;
        logic [31:0] mask;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_hard = 1'b1;
    logic        rst_soft = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = 16'h0;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_od_port u_gpio_od_port (
        .clk       (clk),
        .rst_hard  (rst_hard),
        .rst_soft  (rst_soft),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic do_wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [15:0] e,
                          input logic [15:0] m, input string req);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        it.req = req; it.is_pad = 1'b0;
        it.exp = {16'h0, e}; it.mask = {16'h0, m};
        sb_q.push_back(it);
    endtask

    task automatic chk_pad(input logic [15:0] e_oe, input logic [15:0] e_out,
                           input logic [15:0] m_oe, input logic [15:0] m_out,
                           input string req);
        sb_item_t it;
        @(posedge clk); #1;
        it.req = req; it.is_pad = 1'b1;
        it.exp = {e_oe, e_out}; it.mask = {m_oe, m_out};
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_pad ? {pad_oe, pad_out} : {16'h0, bus_rdata};
                checks++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h mask=%h",
                             it.req, act, it.exp, it.mask);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst_hard = 1'b0;

        // R1: defined bits after hard reset
        chk_rd(2'd1, 16'h0000, 16'hFFC4, "R1 cfg after hard reset");
        chk_rd(2'd0, 16'h0000, 16'hFFFF, "R1 data after hard reset");
        chk_pad(16'h0000, 16'h0000, 16'hFFC7, 16'h0000, "R1 oe after hard reset");

        // R3 and R6 (data 0 pulls low), R8
        do_wr(2'd1, 16'hFFFF);
        chk_rd(2'd1, 16'hFFFB, 16'hFFFF, "R3 reserved bit stays zero");
        chk_pad(16'hFFF8, 16'h0000, 16'hFFFF, 16'hFFFF, "R6 od lines pull low");
        do_wr(2'd0, 16'hFFFF);
        chk_pad(16'hFAF8, 16'hFAFF, 16'hFFFF, 16'hFFFF, "R6 od lines release high");
        chk_pad(16'h0000, 16'h0007, 16'h0007, 16'h0007, "R8 low lines never drive");

        // R4 push-pull patterns
        do_wr(2'd1, 16'hFFF8);
        chk_pad(16'hFFF8, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R4 push-pull all ones");
        do_wr(2'd0, 16'hA5A5);
        chk_pad(16'hFFF8, 16'hA5A5, 16'hFFFF, 16'hFFFF, "R4 push-pull pattern");

        // R9 mixed readback and sync latency
        do_wr(2'd1, 16'hFF00);
        @(posedge clk); #1 pad_in = 16'h3C3C;
        repeat (3) @(posedge clk);
        chk_rd(2'd0, 16'hA53C, 16'hFFFF, "R9 mixed readback");
        #1 pad_in = 16'h00C3;
        chk_rd(2'd0, 16'hA53C, 16'hFFFF, "R9 one edge after pad change");
        chk_rd(2'd0, 16'hA5C3, 16'hFFFF, "R9 two edges after pad change");

        // R5 inputs never drive
        do_wr(2'd1, 16'h0000);
        do_wr(2'd0, 16'hFFFF);
        chk_pad(16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5 all lines input");

        // R7 od enable on input lines
        do_wr(2'd1, 16'h0003);
        chk_pad(16'h0000, 16'hFAFF, 16'hFFFF, 16'hFFFF, "R7 od on input lines");

        // R2 / R10 soft reset
        do_wr(2'd1, 16'h1234);
        do_wr(2'd0, 16'h5A5A);
        @(posedge clk); #1 rst_soft = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst_soft = 1'b0;
        chk_rd(2'd1, 16'h1230, 16'hFFFF, "R2 cfg kept by soft reset");
        chk_rd(2'd0, 16'h00C3, 16'hFFFF, "R10 data cleared by soft reset");

        // R11 unmapped address
        do_wr(2'd2, 16'hFFFF);
        chk_rd(2'd2, 16'h0000, 16'hFFFF, "R11 unmapped reads zero");
        chk_rd(2'd1, 16'h1230, 16'hFFFF, "R11 unmapped write ignored cfg");
        chk_rd(2'd0, 16'h00C3, 16'hFFFF, "R11 unmapped write ignored data");

        // R1 hard reset after full configuration
        do_wr(2'd1, 16'hFFFF);
        do_wr(2'd0, 16'hFFFF);
        @(posedge clk); #1 rst_hard = 1'b1;
        @(posedge clk); #1 rst_hard = 1'b0;
        chk_rd(2'd1, 16'h0000, 16'hFFC4, "R1 dir cleared by hard reset");
        chk_pad(16'h0000, 16'h0000, 16'hFFC0, 16'hFFFF, "R1 pads idle after hard reset");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule